// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

This block runs on the host side of a two-wire serial bus. It finds out when a serial memory has finished its self-timed internal write. It sits above a byte-level bus master and drives it through a command/response port. Each attempt is a Start followed by the control byte carrying the 7-bit device address and a cleared read/write bit. A memory that is still programming leaves that byte unacknowledged. The first acknowledge therefore marks the end of the write cycle.

A poll request carries the device address, a retry budget and a mode bit, and uses a valid/ready handshake. The request is taken only while `req_ready` is high, which holds only when the block is idle. There is no queueing, so a source that offers a request while the block is busy must keep it valid until it is accepted. The command port also uses valid/ready. The block holds `cmd_valid`, `cmd_op` and `cmd_data` steady until the master raises `cmd_ready`. It then waits for exactly one `rsp_valid` pulse before it issues the next command. The block never stalls responses.

When the device acknowledges, the block either closes the bus with a Stop or leaves the transaction open for the next operation, depending on the mode bit. It then pulses `done`. When the budget of refused attempts runs out, it sends a Stop and pulses `timeout`.

Top module: `ack_poll_seq`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A request offered while the block is busy changes neither the command stream nor the outcome of the poll in progress.
- R2: Each attempt issues a command with `cmd_op`=0 (Start) and then a command with `cmd_op`=1 (byte write). The write command carries `cmd_data` = {address[6:0], 1'b0}, so bit 0 (read/write) is zero. `cmd_op`=2 is Stop.
- R3: Once `cmd_valid` is high, it stays high with `cmd_op` and `cmd_data` unchanged until `cmd_ready` is sampled high. After a command is accepted, `cmd_valid` stays low until that command's `rsp_valid` arrives.
- R4: The first Start is presented in the cycle that follows acceptance, with no fixed wait.
- R5: A write response with `rsp_nack`=1 that leaves budget remaining is followed in the next cycle by a new Start, with no Stop in between.
- R6: With `req_keep_open`=0, an acknowledged write (`rsp_nack`=0) is followed by a Stop. `done` rises in the cycle after the Stop's response.
- R7: With `req_keep_open`=1, an acknowledged write raises `done` in the cycle after the write response, and no Stop is issued.
- R8: The poll gives up when the number of refused writes reaches `req_limit`, where a limit of 0 counts as 1. It then issues a Stop and raises `timeout` in the cycle after the Stop's response. The total number of attempts equals max(`req_limit`,1).
- R9: `done` and `timeout` are each high for one cycle only, and never both at once.
- R10: After reset, `req_ready`=1, `cmd_valid`=0, `done`=0 and `timeout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Poll request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 7 | Device address (type code and chip-select bits) |
| req_limit | input | CNT_W (8) | Maximum refused attempts |
| req_keep_open | input | 1 | 1: skip the Stop after the acknowledge |
| cmd_valid | output | 1 | Command presented to the byte master |
| cmd_ready | input | 1 | Master accepts the command |
| cmd_op | output | 2 | 0 Start, 1 write byte, 2 Stop |
| cmd_data | output | 8 | Byte to send for a write command |
| rsp_valid | input | 1 | One-cycle completion of the accepted command |
| rsp_nack | input | 1 | Acknowledge bit of a write (1 = refused) |
| done | output | 1 | One-cycle pulse: device acknowledged |
| timeout | output | 1 | One-cycle pulse: budget exhausted |

## Verification
The assertions check on every cycle the properties that hold at each edge. These are the command hold under back-pressure, the clear read/write bit in every write byte, the fall of `req_ready` after an accept, the single-cycle and exclusive result pulses, the Stop that precedes a timeout, and the retry count staying below the budget. Only the bench scenarios can show the sequence-level behaviour. That covers the exact order of Start, write and Stop and the number of attempts for a given busy period and limit. It also covers whether a final Stop is skipped in open mode, the zero-limit case, and whether a request offered mid-poll is really ignored.

// File: rtl/ack_poll_pkg.sv
package ack_poll_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_STOP  = 2'd2
  } poll_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_RSP  = 2'd2
  } poll_state_e;
endpackage

// File: rtl/ack_poll_retry.sv
module ack_poll_retry #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  input  logic [CNT_W-1:0] limit,
  output logic             last_try
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] refused_q;
  logic [EXT_W-1:0] next_ext;

  assign next_ext = {1'b0, refused_q} + EXT_W'(1);
  assign last_try = next_ext >= {1'b0, limit};

  always_ff @(posedge clk) begin
    if (!rst_n)     refused_q <= '0;
    else if (clear) refused_q <= '0;
    else if (bump)  refused_q <= refused_q + CNT_W'(1);
  end

  // Refused attempts counted so far never reach the budget in force.
  assert_count_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0) |-> (refused_q < limit));
endmodule

// File: rtl/ack_poll_fsm.sv
module ack_poll_fsm
  import ack_poll_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     keep_open,
  input  logic     cmd_ready,
  input  logic     rsp_valid,
  input  logic     rsp_nack,
  input  logic     last_try,
  output logic     req_ready,
  output logic     accept,
  output logic     bump,
  output logic     cmd_valid,
  output poll_op_e cmd_op,
  output logic     done,
  output logic     timeout
);
  poll_state_e st_q;
  poll_op_e    op_q;
  logic        to_q;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign cmd_valid = (st_q == ST_CMD);
  assign cmd_op    = op_q;
  assign bump      = (st_q == ST_RSP) && rsp_valid && (op_q == OP_WRITE) && rsp_nack && !last_try;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_START;
      to_q    <= 1'b0;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          op_q <= OP_START;
          to_q <= 1'b0;
          st_q <= ST_CMD;
        end
        ST_CMD: if (cmd_ready) st_q <= ST_RSP;
        ST_RSP: if (rsp_valid) begin
          unique case (op_q)
            OP_START: begin
              op_q <= OP_WRITE;
              st_q <= ST_CMD;
            end
            OP_WRITE: begin
              if (!rsp_nack) begin
                if (keep_open) begin
                  done <= 1'b1;
                  st_q <= ST_IDLE;
                end else begin
                  op_q <= OP_STOP;
                  st_q <= ST_CMD;
                end
              end else if (last_try) begin
                op_q <= OP_STOP;
                to_q <= 1'b1;
                st_q <= ST_CMD;
              end else begin
                op_q <= OP_START;
                st_q <= ST_CMD;
              end
            end
            OP_STOP: begin
              if (to_q) timeout <= 1'b1;
              else      done    <= 1'b1;
              st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
          endcase
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op)));
  assert_accept_leaves_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |=> !(done || timeout));
  assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));
  assert_timeout_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (cmd_op == OP_STOP));
endmodule

// File: rtl/ack_poll_seq.sv
module ack_poll_seq
  import ack_poll_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_limit,
  input  logic              req_keep_open,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W:0]   cmd_data,
  input  logic              rsp_valid,
  input  logic              rsp_nack,
  output logic              done,
  output logic              timeout
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  limit_q;
  logic              keep_q;
  logic              accept;
  logic              bump;
  logic              last_try;
  poll_op_e          op;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      limit_q <= '0;
      keep_q  <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      limit_q <= req_limit;
      keep_q  <= req_keep_open;
    end
  end

  ack_poll_retry #(.CNT_W(CNT_W)) u_retry (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .bump     (bump),
    .limit    (limit_q),
    .last_try (last_try)
  );

  ack_poll_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .keep_open (keep_q),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_nack  (rsp_nack),
    .last_try  (last_try),
    .req_ready (req_ready),
    .accept    (accept),
    .bump      (bump),
    .cmd_valid (cmd_valid),
    .cmd_op    (op),
    .done      (done),
    .timeout   (timeout)
  );

  assign cmd_op   = op;
  assign cmd_data = (op == OP_WRITE) ? {addr_q, 1'b0} : '0;

  assert_write_bit_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 2'd1)) |-> (cmd_data[0] == 1'b0));
  assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> $stable(cmd_data));
endmodule

// File: tb/tb_ack_poll_seq.sv
module tb_ack_poll_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [6:0] req_addr = '0;
  logic [7:0] req_limit = '0;
  logic       req_keep_open = 1'b0;
  logic       cmd_valid;
  logic       cmd_ready = 1'b0;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data;
  logic       rsp_valid = 1'b0;
  logic       rsp_nack = 1'b0;
  logic       done;
  logic       timeout;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  ack_poll_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_limit(req_limit), .req_keep_open(req_keep_open),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .done(done), .timeout(timeout)
  );

  function automatic logic [7:0] ctrl_byte(input logic [6:0] a);
    return {a, 1'b0};
  endfunction

  function automatic int budget(input int lim);
    return (lim == 0) ? 1 : lim;
  endfunction

  function automatic int exp_attempts(input int lim, input int busy);
    return (busy >= budget(lim)) ? budget(lim) : busy + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [6:0] addr, input int lim, input bit keep,
                          input int busy, input bit intrude);
    int  exp_op;
    int  writes;
    int  nacks;
    int  rsp_cd;
    int  last_op;
    bit  fin;
    bit  exp_to;
    bit  gap_chk;
    bit  busy_ok;
    bit  stop_seen;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready before request", req_ready, 1);
    req_valid = 1'b1; req_addr = addr; req_limit = 8'(lim); req_keep_open = keep;
    @(negedge clk);
    check(cmd_valid == 1'b1 && cmd_op == 2'd0, "R4 start right after accept", cmd_op, 0);
    if (intrude) begin
      req_addr = addr ^ 7'h55; req_limit = 8'd0; req_keep_open = ~keep;
    end else req_valid = 1'b0;
    exp_op = 0; writes = 0; nacks = 0; rsp_cd = 0; last_op = 0;
    fin = 0; exp_to = 0; gap_chk = 0; busy_ok = 1; stop_seen = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      rsp_valid = 1'b0; cmd_ready = 1'b0;
      if (fin) begin
        check(done == !exp_to && timeout == exp_to, exp_to ? "R8 timeout pulse" : "R6/R7 done pulse",
              {done, timeout}, exp_to ? 1 : 2);
        @(negedge clk);
        check(!done && !timeout && req_ready, "R9 single pulse", {done, timeout}, 0);
        break;
      end
      if (req_ready || done || timeout) busy_ok = 0;
      if (gap_chk) begin
        check(cmd_valid == 1'b1, "R5 next command without gap", cmd_valid, 1);
        gap_chk = 0;
      end
      if (rsp_cd > 0) begin
        if (cmd_valid) check(1'b0, "R3 command while awaiting response", 1, 0);
        rsp_cd--;
        if (rsp_cd == 0) begin
          rsp_valid = 1'b1;
          if (last_op == 1) begin
            rsp_nack = (writes <= busy);
            if (rsp_nack) begin
              nacks++;
              if (nacks >= budget(lim)) begin exp_op = 2; exp_to = 1; end
              else exp_op = 0;
              gap_chk = 1;
            end else if (keep) begin
              fin = 1; req_valid = 1'b0;
            end else begin
              exp_op = 2; gap_chk = 1;
            end
          end else if (last_op == 0) begin
            rsp_nack = 1'($urandom % 2); exp_op = 1; gap_chk = 1;
          end else begin
            rsp_nack = 1'($urandom % 2); fin = 1; req_valid = 1'b0;
          end
        end
      end else if (cmd_valid) begin
        if (($urandom % 3) != 0) begin
          cmd_ready = 1'b1;
          check(cmd_op == 2'(exp_op), "R2 command order", cmd_op, exp_op);
          if (exp_op == 1) begin
            writes++;
            check(cmd_data == ctrl_byte(addr), "R2 control byte", cmd_data, ctrl_byte(addr));
          end
          if (exp_op == 2) stop_seen = 1;
          last_op = exp_op;
          rsp_cd = 1 + int'($urandom % 3);
        end
      end
      @(negedge clk);
      if (cmd_ready && rsp_cd > 0) check(cmd_valid == 1'b0, "R3 wait for response", cmd_valid, 0);
    end
    req_valid = 1'b0;
    check(fin, "R8 poll finished", fin, 1);
    check(busy_ok, intrude ? "R1 ignored while busy" : "R1 busy not ready", busy_ok, 1);
    check(writes == exp_attempts(lim, busy), "R8 attempt count", writes, exp_attempts(lim, busy));
    check(stop_seen == !(keep && !exp_to), keep ? "R7 no stop in open mode" : "R6 stop issued",
          stop_seen, !(keep && !exp_to));
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !cmd_valid && !done && !timeout, "R10 reset state",
          {req_ready, cmd_valid, done, timeout}, 8);
    run_case(7'h50, 3, 1'b0, 0, 1'b0);
    run_case(7'h53, 3, 1'b1, 0, 1'b0);
    run_case(7'h51, 4, 1'b0, 3, 1'b1);
    run_case(7'h57, 4, 1'b0, 4, 1'b0);
    run_case(7'h52, 0, 1'b1, 2, 1'b0);
    run_case(7'h55, 2, 1'b1, 9, 1'b1);
    for (int k = 0; k < 24; k++)
      run_case(7'($urandom), int'($urandom % 6), 1'($urandom % 2),
               int'($urandom % 8), 1'($urandom % 2));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule